// File: doc/BRIEF.md
# Oversampled Serial Receiver with 256-Character Queue

This block is the receive half of a 16550-style serial port. It synchronises the asynchronous input line and samples it sixteen times per bit, paced by a 16-bit programmable divisor. It frames each character from a start bit, eight data bits, an optional parity bit and a stop bit, then stores it in a 256-entry queue. Each queue entry keeps its own parity, framing and break flags.

A host reads the block through a one-cycle register read port. One select value returns the character at the head of the queue and removes it. The other returns the line status byte. A receive request goes high when the queue holds at least the character count picked by a 2-bit trigger selector. A line interrupt reports error conditions when the host enables it.

Top module: `serial_rx_fifo`

## Requirements
- R1: The oversampling tick runs once every `max(divisor,1)` clock cycles, and one bit time is 16 ticks. A divisor of 0 behaves exactly like a divisor of 1.
- R2: A character starts only on a high-to-low change of the line. A low pulse that is gone by the middle of the start bit is rejected and stores nothing.
- R3: Status bit 0 (data ready) is 1 while the queue holds a character. Reading the data register (`rd_sel`=0) returns the head character, least significant bit received first, and removes it.
- R4: When `par_en`=1 a parity bit follows the data. `par_even`=1 selects even parity and 0 selects odd parity. A mismatch sets status bit 2 while that character is at the head.
- R5: A low stop bit on a character that is not a break sets status bit 3 while that character is at the head.
- R6: A break (data, parity and stop all low) stores exactly one character of value 0x00, which sets status bit 4 at the head. No further character is framed until the line has been high again.
- R7: The queue holds 256 characters. A character that completes while the queue is full is dropped and sets status bit 1 (overrun). A status read (`rd_sel`=1) clears the overrun bit. An overrun that occurs in the same cycle as a status read is set after that read.
- R8: Status bit 7 is 1 while any stored character, not only the head, carries a parity, framing or break flag.
- R9: `rx_avail_req` is 1 while the fill level is at least the trigger level. `trig_sel` encodes 00=8, 01=16, 10=56 and 11=60 characters.
- R10: After reset the status byte reads 0x60 (bits 5 and 6 high, all others low), and both `rx_avail_req` and `line_irq` are 0.
- R11: `line_irq` equals `lsr_irq_en` AND (status bits 1 to 4 OR-ed together).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| divisor | input | 16 | Clock cycles per oversampling tick (0 acts as 1) |
| par_en | input | 1 | Expect a parity bit after the data |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| trig_sel | input | 2 | Receive trigger level select |
| lsr_irq_en | input | 1 | Enable for the line status interrupt |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rd_en | input | 1 | Register read strobe, one cycle per read |
| rd_sel | input | 1 | 0 = receive data, 1 = line status |
| rd_data | output | 8 | Read data for the selected register |
| rx_avail_req | output | 1 | Fill level has reached the trigger level |
| line_irq | output | 1 | Line status interrupt |

## Verification
The embedded assertions check on every cycle that ticks do not run back to back at divisors above one and that a break is stored with zero data. They also check that a push into a full queue leaves the fill level unchanged, that an overrun coinciding with a status read is set after that read, that the receive request never rises below the smallest trigger level, and that the error summary bit covers a flagged head character. The bench scenarios are needed to show the end-to-end behaviour: bit-centre sampling at several divisors, glitch rejection, parity and framing classification, and the single character per break. They also show first-in-first-out order across 256 entries with the 257th dropped, and each of the four trigger thresholds at its exact boundary.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [CHAR_W-1:0] data;
  } rx_char_t;

  // a zero divisor is treated as one
  function automatic logic [15:0] eff_div(input logic [15:0] d);
    return (d == 16'd0) ? 16'd1 : d;
  endfunction

  // receive trigger thresholds in characters
  function automatic int trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 8;
      2'b01:   return 16;
      2'b10:   return 56;
      default: return 60;
    endcase
  endfunction

  // expected parity bit for the data
  function automatic logic calc_parity(input logic [CHAR_W-1:0] d, input logic even);
    return even ? (^d) : ~(^d);
  endfunction
endpackage

// File: rtl/rx_baud_gen.sv
module rx_baud_gen
  import rxq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] divisor,
  output logic        tick
);
  logic [15:0] cnt;
  logic [15:0] div_eff;

  assign div_eff = eff_div(divisor);
  assign tick    = (cnt >= div_eff - 16'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 16'd1;
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_eff > 16'd1) |=> (!tick || !$stable(divisor)));
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import rxq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     rxd_s,
  input  logic     par_en,
  input  logic     par_even,
  output logic     push,
  output rx_char_t push_char
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} fr_state_t;

  localparam logic [3:0] MID_TICK = 4'd7;
  localparam logic [3:0] END_TICK = 4'd15;
  localparam int         BW       = $clog2(CHAR_W);

  fr_state_t         state;
  logic [3:0]        tcnt;
  logic [BW-1:0]     bitn;
  logic [CHAR_W-1:0] shreg;
  logic              pbit;
  logic              armed;
  logic              brk_w, ferr_w, perr_w;

  assign brk_w  = (shreg == '0) && !rxd_s && (!par_en || !pbit);
  assign ferr_w = !rxd_s && !brk_w;
  assign perr_w = par_en && !brk_w && (pbit != calc_parity(shreg, par_even));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      tcnt      <= '0;
      bitn      <= '0;
      shreg     <= '0;
      pbit      <= 1'b0;
      armed     <= 1'b0;
      push      <= 1'b0;
      push_char <= '0;
    end else begin
      push <= 1'b0;
      if (state == S_IDLE && rxd_s) armed <= 1'b1;
      if (tick) begin
        case (state)
          S_IDLE: if (armed && !rxd_s) begin
            state <= S_START;
            tcnt  <= '0;
          end
          S_START: begin
            tcnt <= tcnt + 4'd1;
            if (tcnt == MID_TICK) begin
              tcnt <= '0;
              bitn <= '0;
              state <= rxd_s ? S_IDLE : S_DATA;
            end
          end
          S_DATA: begin
            tcnt <= tcnt + 4'd1;
            if (tcnt == END_TICK) begin
              shreg <= {rxd_s, shreg[CHAR_W-1:1]};
              bitn  <= bitn + 1'b1;
              if (bitn == BW'(CHAR_W - 1)) state <= par_en ? S_PAR : S_STOP;
            end
          end
          S_PAR: begin
            tcnt <= tcnt + 4'd1;
            if (tcnt == END_TICK) begin
              pbit  <= rxd_s;
              state <= S_STOP;
            end
          end
          S_STOP: begin
            tcnt <= tcnt + 4'd1;
            if (tcnt == END_TICK) begin
              push           <= 1'b1;
              push_char.data <= shreg;
              push_char.brk  <= brk_w;
              push_char.ferr <= ferr_w;
              push_char.perr <= perr_w;
              armed          <= 1'b0;
              state          <= S_IDLE;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R6
  break_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_char.brk) |-> (push_char.data == '0));
endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  rx_char_t        push_char,
  input  logic            pop,
  output rx_char_t        head,
  output logic [$clog2(DEPTH):0] count,
  output logic            empty,
  output logic            overflow,
  output logic            any_err
);
  localparam int AW = $clog2(DEPTH);

  rx_char_t         mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      err_cnt;
  logic             full, do_push, do_pop, in_err, head_err;

  assign full     = (count == (AW+1)'(DEPTH));
  assign empty    = (count == '0);
  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;
  assign overflow = push && full;
  assign head     = mem[rd_ptr];
  assign in_err   = push_char.brk | push_char.ferr | push_char.perr;
  assign head_err = head.brk | head.ferr | head.perr;
  assign any_err  = (err_cnt != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_char;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      err_cnt <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      count   <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
      err_cnt <= err_cnt + (AW+1)'(do_push && in_err) - (AW+1)'(do_pop && head_err);
    end
  end

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == $past(count)));

  // R8
  err_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && head_err) |-> any_err);
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] divisor,
  input  logic        par_en,
  input  logic        par_even,
  input  logic [1:0]  trig_sel,
  input  logic        lsr_irq_en,
  input  logic        rxd,
  input  logic        rd_en,
  input  logic        rd_sel,
  output logic [7:0]  rd_data,
  output logic        rx_avail_req,
  output logic        line_irq
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [1:0]    sync_q;
  logic          tick, push, empty, ovr_evt, any_err, oe_q;
  logic          rd_rhr, rd_lsr;
  rx_char_t      push_char, head;
  logic [CW-1:0] count;
  logic [7:0]    lsr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end

  rx_baud_gen u_baud (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
  );

  rx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd_s(sync_q[1]),
    .par_en(par_en), .par_even(par_even), .push(push), .push_char(push_char)
  );

  rx_char_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_char(push_char),
    .pop(rd_rhr), .head(head), .count(count), .empty(empty),
    .overflow(ovr_evt), .any_err(any_err)
  );

  assign rd_rhr = rd_en && !rd_sel;
  assign rd_lsr = rd_en &&  rd_sel;

  // overrun is sticky; a read clears it, and an event during the read lands after it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       oe_q <= 1'b0;
    else if (rd_lsr)  oe_q <= ovr_evt;
    else if (ovr_evt) oe_q <= 1'b1;
  end

  assign lsr_val = {any_err, 2'b11,
                    head.brk  & !empty,
                    head.ferr & !empty,
                    head.perr & !empty,
                    oe_q, !empty};

  assign rd_data      = rd_sel ? lsr_val : (empty ? 8'h00 : head.data);
  assign rx_avail_req = (int'(count) >= trig_level(trig_sel));
  assign line_irq     = lsr_irq_en & (|lsr_val[4:1]);

  // R7
  oe_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && ovr_evt) |=> oe_q);

  // R9
  req_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_avail_req |-> (int'(count) >= 8));
endmodule

// File: tb/test_serial_rx_fifo.sv
module test_serial_rx_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] divisor = 16'd1;
  logic        par_en = 1'b0, par_even = 1'b1;
  logic [1:0]  trig_sel = 2'b00;
  logic        lsr_irq_en = 1'b0;
  logic        rxd = 1'b1;
  logic        rd_en = 1'b0, rd_sel = 1'b0;
  logic [7:0]  rd_data;
  logic        rx_avail_req, line_irq;

  int vectors = 0;
  int miscompares = 0;
  int bt = 16;

  always #2 clk = ~clk;

  serial_rx_fifo i_serial_rx_fifo (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .par_en(par_en),
    .par_even(par_even), .trig_sel(trig_sel), .lsr_irq_en(lsr_irq_en),
    .rxd(rxd), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .rx_avail_req(rx_avail_req), .line_irq(line_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int cyc);
    rxd = v;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input bit stop_v);
    logic p;
    p = par_even ? (^d) : ~(^d);
    hold(1'b0, bt);
    for (int i = 0; i < 8; i++) hold(d[i], bt);
    if (par_en) hold(p ^ bad_par, bt);
    hold(stop_v, bt);
    hold(1'b1, bt);
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_div(input logic [15:0] d);
    divisor = d;
    bt = 16 * ((d == 16'd0) ? 1 : int'(d));
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(1'b1, v);
    check("R10 reset status", v, 8'h60);
    check("R10 reset req", rx_avail_req, 1'b0);
    check("R10 reset irq", line_irq, 1'b0);
  endtask

  task automatic t_basic;
    logic [7:0] v;
    send(8'hA5, 0, 1);
    rd(1'b1, v); check("R3 ready set", v, 8'h61);
    rd(1'b0, v); check("R3 data", v, 8'hA5);
    rd(1'b1, v); check("R3 ready clear", v, 8'h60);
  endtask

  task automatic t_divisors;
    logic [7:0] v;
    set_div(16'd0);
    send(8'h3B, 0, 1);
    rd(1'b0, v); check("R1 divisor zero", v, 8'h3B);
    set_div(16'd3);
    send(8'hC6, 0, 1);
    rd(1'b0, v); check("R1 divisor three", v, 8'hC6);
    set_div(16'd1);
  endtask

  task automatic t_glitch;
    logic [7:0] v;
    hold(1'b0, 4);
    hold(1'b1, 3 * bt);
    rd(1'b1, v); check("R2 glitch rejected", v, 8'h60);
  endtask

  task automatic t_parity;
    logic [7:0] v;
    par_en = 1'b1; par_even = 1'b1; lsr_irq_en = 1'b1;
    send(8'h3C, 0, 1);
    send(8'h71, 1, 1);
    rd(1'b1, v); check("R8 error behind head", v, 8'hE1);
    check("R11 no irq for clean head", line_irq, 1'b0);
    rd(1'b0, v); check("R4 good char", v, 8'h3C);
    rd(1'b1, v); check("R4 parity error flag", v, 8'hE5);
    check("R11 irq enabled", line_irq, 1'b1);
    lsr_irq_en = 1'b0; #1;
    check("R11 irq masked", line_irq, 1'b0);
    rd(1'b0, v); check("R4 bad char data", v, 8'h71);
    par_even = 1'b0;
    send(8'h71, 0, 1);
    rd(1'b1, v); check("R4 odd parity ok", v, 8'h61);
    rd(1'b0, v);
    par_en = 1'b0; par_even = 1'b1;
  endtask

  task automatic t_framing;
    logic [7:0] v;
    send(8'h55, 0, 0);
    rd(1'b1, v); check("R5 framing flag", v, 8'hE9);
    rd(1'b0, v); check("R5 framing data", v, 8'h55);
  endtask

  task automatic t_break;
    logic [7:0] v;
    lsr_irq_en = 1'b1;
    hold(1'b0, 20 * bt);
    hold(1'b1, 2 * bt);
    rd(1'b1, v); check("R6 break status", v, 8'hF1);
    check("R11 break irq", line_irq, 1'b1);
    rd(1'b0, v); check("R6 break data", v, 8'h00);
    rd(1'b1, v); check("R6 single char", v, 8'h60);
    lsr_irq_en = 1'b0;
  endtask

  task automatic t_trigger(input logic [1:0] sel, input int lvl);
    logic [7:0] v;
    trig_sel = sel;
    for (int i = 0; i < lvl - 1; i++) send(8'(i), 0, 1);
    check($sformatf("R9 below level %0d", lvl), rx_avail_req, 1'b0);
    send(8'hEE, 0, 1);
    check($sformatf("R9 at level %0d", lvl), rx_avail_req, 1'b1);
    rd(1'b0, v);
    check($sformatf("R9 drop below %0d", lvl), rx_avail_req, 1'b0);
    for (int i = 0; i < lvl - 1; i++) rd(1'b0, v);
  endtask

  task automatic t_overrun;
    logic [7:0] v;
    int bad;
    bad = 0;
    for (int i = 0; i < 257; i++) send(8'(i), 0, 1);
    rd(1'b1, v); check("R7 overrun set", v, 8'h63);
    rd(1'b1, v); check("R7 overrun cleared by read", v, 8'h61);
    for (int i = 0; i < 256; i++) begin
      rd(1'b0, v);
      if (v !== 8'(i)) bad++;
    end
    check("R7 order over 256 entries", bad, 0);
    rd(1'b1, v); check("R7 extra char dropped", v, 8'h60);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    t_reset;
    t_basic;
    t_divisors;
    t_glitch;
    t_parity;
    t_framing;
    t_break;
    t_trigger(2'b00, 8);
    t_trigger(2'b01, 16);
    t_trigger(2'b10, 56);
    t_trigger(2'b11, 60);
    t_overrun;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule